// File: doc/BRIEF.md
# X-Space Memory Address Router

This block sits between the load/store unit of a 24-bit DSP core and its data memories. Every access arrives on one request port carrying a space code, a 24-bit address, a write enable and a write word. The router decodes the address into a target and performs the access there. The possible targets are the general X RAM, a mix buffer, the Y RAM, the P RAM, and an external peripheral bus. Read data appears one clock after the request, whatever the target.

In X space, the general RAM fills the bottom of the map and the mix buffer follows directly above it. The same mix-buffer storage is also decoded at a second, higher window, so software can reach one word through either address. The top of X space is handed to a peripheral bus. That bus gets a select, a write strobe, a word index and write data in the request cycle, and it returns read data in that same cycle. The peripheral window is checked first. Y and P space each map to a single RAM. Any access that hits no window raises an error pulse. An erroneous read returns zero and an erroneous write changes nothing.

Top module: `xmem_router`

## Requirements
- R1: In space X (code 0), addresses 0 to 3071 address the general X RAM. A read returns the last word written there on `rd_data` in the cycle after the request.
- R2: In space X, addresses 3072 to 4095 address the 1024-word mix buffer. Word index = address − 3072.
- R3: In space X, addresses 5120 to 6143 address the same mix-buffer storage, with word index = address − 5120. A word written through one window reads back through the other.
- R4: Space Y (code 1) maps addresses 0 to 2047 to a 2048-word RAM. Space P (code 2) maps addresses 0 to 4095 to a 4096-word RAM. The same address in different spaces holds independent words.
- R5: A space-X request with address ≥ 0xFFFF80 asserts `periph_sel` in the request cycle. It drives `periph_addr` = address − 0xFFFF80 (7 bits), `periph_we` = the request's write enable and `periph_wdata` = its write word. A read returns the `periph_rdata` sampled in that cycle on `rd_data` one cycle later. This decode wins over all others and touches no RAM.
- R6: A request that hits no window sets `addr_err` for exactly the one cycle after it. This covers X addresses 4096–5119, 6144–0xFFFF7F, Y ≥ 2048, P ≥ 4096, and space code 3. `rd_data` is zero in that cycle.
- R7: A write that raises `addr_err` changes no RAM word.
- R8: After reset, `rd_data`, `addr_err` and `periph_sel` are all zero.
- R9: In the cycle after an idle cycle or after a write, `rd_data` is zero and `addr_err` stays low unless the write was unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Request valid this cycle |
| req_space | input | 2 | Space code: 0 = X, 1 = Y, 2 = P |
| req_addr | input | 24 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 24 | Write word |
| rd_data | output | 24 | Read result, one cycle after the request |
| addr_err | output | 1 | Unmapped-access pulse, one cycle after the request |
| periph_sel | output | 1 | Peripheral access this cycle |
| periph_we | output | 1 | Peripheral write strobe |
| periph_addr | output | 7 | Peripheral word index |
| periph_wdata | output | 24 | Peripheral write word |
| periph_rdata | input | 24 | Peripheral read word, same cycle |

## Verification
The error pulse of one request falls in the same cycle as the peripheral strobe of the next. The bench provokes this by issuing an unmapped read and then, back to back, a peripheral read. It then checks that `addr_err` and `periph_sel` are both high in that cycle. In the following cycle it checks that the peripheral read data arrives with the error flag already cleared. Around this case, the bench sweeps every word of each RAM and of both mix-buffer windows against arithmetic patterns.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

   typedef enum logic [1:0] {
      SP_X   = 2'd0,
      SP_Y   = 2'd1,
      SP_P   = 2'd2,
      SP_BAD = 2'd3
   } space_e;

   // Bank targets 0..3 double as bank indices
   typedef enum logic [2:0] {
      TG_XRAM   = 3'd0,
      TG_MIX    = 3'd1,
      TG_YRAM   = 3'd2,
      TG_PRAM   = 3'd3,
      TG_PERIPH = 3'd4,
      TG_NONE   = 3'd5
   } target_e;

   localparam int NUM_BANKS = 4;

endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
   import xmem_pkg::*;
#(
   parameter int AW             = 24,
   parameter int IDX_W          = 12,
   parameter int XRAM_WORDS     = 3072,
   parameter int MIX_WORDS      = 1024,
   parameter bit MIX_ALIAS_EN   = 1'b1,
   parameter int MIX_ALIAS_BASE = 5120,
   parameter int YRAM_WORDS     = 2048,
   parameter int PRAM_WORDS     = 4096,
   parameter int PERIPH_BASE    = 24'hFFFF80
) (
   input  logic [1:0]       space,
   input  logic [AW-1:0]    addr,
   output target_e          tgt,
   output logic [IDX_W-1:0] idx
);
   localparam logic [AW-1:0] MIX_LO   = AW'(XRAM_WORDS);
   localparam logic [AW-1:0] MIX_HI   = AW'(XRAM_WORDS + MIX_WORDS);
   localparam logic [AW-1:0] ALIAS_LO = AW'(MIX_ALIAS_BASE);
   localparam logic [AW-1:0] ALIAS_HI = AW'(MIX_ALIAS_BASE + MIX_WORDS);
   localparam logic [AW-1:0] PER_LO   = AW'(PERIPH_BASE);

   logic alias_hit;

   generate
      if (MIX_ALIAS_EN) begin : g_alias
         assign alias_hit = (addr >= ALIAS_LO) && (addr < ALIAS_HI);
      end else begin : g_no_alias
         assign alias_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      tgt = TG_NONE;
      idx = '0;
      unique case (space_e'(space))
         SP_X: begin
            if (addr >= PER_LO) begin
               tgt = TG_PERIPH;
               idx = IDX_W'(addr - PER_LO);
            end else if (addr < MIX_LO) begin
               tgt = TG_XRAM;
               idx = IDX_W'(addr);
            end else if (addr < MIX_HI) begin
               tgt = TG_MIX;
               idx = IDX_W'(addr - MIX_LO);
            end else if (alias_hit) begin
               tgt = TG_MIX;
               idx = IDX_W'(addr - ALIAS_LO);
            end
         end
         SP_Y: begin
            if (addr < AW'(YRAM_WORDS)) begin
               tgt = TG_YRAM;
               idx = IDX_W'(addr);
            end
         end
         SP_P: begin
            if (addr < AW'(PRAM_WORDS)) begin
               tgt = TG_PRAM;
               idx = IDX_W'(addr);
            end
         end
         default: begin
            tgt = TG_NONE;
            idx = '0;
         end
      endcase
   end

endmodule

// File: rtl/xmem_bank.sv
module xmem_bank #(
   parameter int DW    = 24,
   parameter int DEPTH = 1024,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [IW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) begin
         mem[addr] <= wdata;
      end
      if (en && !we) begin
         rdata <= mem[addr];
      end
   end

endmodule

// File: rtl/xmem_router.sv
module xmem_router
   import xmem_pkg::*;
#(
   parameter int DW             = 24,
   parameter int AW             = 24,
   parameter int XRAM_WORDS     = 3072,
   parameter int MIX_WORDS      = 1024,
   parameter bit MIX_ALIAS_EN   = 1'b1,
   parameter int MIX_ALIAS_BASE = 5120,
   parameter int YRAM_WORDS     = 2048,
   parameter int PRAM_WORDS     = 4096,
   parameter int PERIPH_BASE    = 24'hFFFF80,
   localparam int PER_WORDS     = (1 << AW) - PERIPH_BASE,
   localparam int PER_W         = $clog2(PER_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_en,
   input  logic [1:0]       req_space,
   input  logic [AW-1:0]    req_addr,
   input  logic             req_we,
   input  logic [DW-1:0]    req_wdata,
   output logic [DW-1:0]    rd_data,
   output logic             addr_err,
   output logic             periph_sel,
   output logic             periph_we,
   output logic [PER_W-1:0] periph_addr,
   output logic [DW-1:0]    periph_wdata,
   input  logic [DW-1:0]    periph_rdata
);
   function automatic int bank_depth(input int b);
      case (b)
         0:       return XRAM_WORDS;
         1:       return MIX_WORDS;
         2:       return YRAM_WORDS;
         default: return PRAM_WORDS;
      endcase
   endfunction

   function automatic int max_width();
      int w;
      w = PER_W;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if ($clog2(bank_depth(b)) > w) w = $clog2(bank_depth(b));
      end
      return w;
   endfunction

   localparam int IDX_W = max_width();

   // elaboration-time configuration checks
   generate
      if (XRAM_WORDS + MIX_WORDS > PERIPH_BASE) begin : g_bad_low
         $error("mix buffer overlaps peripheral window");
      end
      if (MIX_ALIAS_EN && (MIX_ALIAS_BASE < XRAM_WORDS + MIX_WORDS)) begin : g_bad_alias
         $error("alias window overlaps primary windows");
      end
      if (MIX_ALIAS_EN && (MIX_ALIAS_BASE + MIX_WORDS > PERIPH_BASE)) begin : g_bad_alias_hi
         $error("alias window overlaps peripheral window");
      end
      if ((PER_WORDS & (PER_WORDS - 1)) != 0) begin : g_bad_per
         $error("peripheral window must be a power of two");
      end
   endgenerate

   target_e          dec_tgt;
   logic [IDX_W-1:0] dec_idx;
   target_e          tgt_q;
   logic             err_q;
   logic [DW-1:0]    per_q;
   logic [DW-1:0]    bank_q [NUM_BANKS];

   xmem_decode #(
      .AW(AW), .IDX_W(IDX_W), .XRAM_WORDS(XRAM_WORDS), .MIX_WORDS(MIX_WORDS),
      .MIX_ALIAS_EN(MIX_ALIAS_EN), .MIX_ALIAS_BASE(MIX_ALIAS_BASE),
      .YRAM_WORDS(YRAM_WORDS), .PRAM_WORDS(PRAM_WORDS), .PERIPH_BASE(PERIPH_BASE)
   ) u_dec (
      .space(req_space),
      .addr (req_addr),
      .tgt  (dec_tgt),
      .idx  (dec_idx)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int D  = bank_depth(b);
         localparam int BW = (D > 1) ? $clog2(D) : 1;
         logic bank_en;
         assign bank_en = req_en && (dec_tgt == target_e'(b));
         xmem_bank #(.DW(DW), .DEPTH(D)) u_bank (
            .clk  (clk),
            .en   (bank_en),
            .we   (req_we),
            .addr (dec_idx[BW-1:0]),
            .wdata(req_wdata),
            .rdata(bank_q[b])
         );
      end
   endgenerate

   assign periph_sel   = req_en && (dec_tgt == TG_PERIPH);
   assign periph_we    = periph_sel && req_we;
   assign periph_addr  = dec_idx[PER_W-1:0];
   assign periph_wdata = req_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= TG_NONE;
         err_q <= 1'b0;
         per_q <= '0;
      end else begin
         err_q <= req_en && (dec_tgt == TG_NONE);
         tgt_q <= (req_en && !req_we) ? dec_tgt : TG_NONE;
         if (periph_sel && !req_we) begin
            per_q <= periph_rdata;
         end
      end
   end

   always_comb begin
      unique case (tgt_q)
         TG_XRAM, TG_MIX, TG_YRAM, TG_PRAM: rd_data = bank_q[tgt_q[1:0]];
         TG_PERIPH:                         rd_data = per_q;
         default:                           rd_data = '0;
      endcase
   end

   assign addr_err = err_q;

   // R6
   err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> rd_data == '0);

   // R5
   periph_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_sel |=> !addr_err);

   // R5
   periph_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_we |-> periph_sel && req_space == 2'd0);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_en |=> (!addr_err && rd_data == '0));

   // R9
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && req_we) |=> rd_data == '0);

endmodule

// File: tb/xmem_router_test.sv
module xmem_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_en = 1'b0;
   logic [1:0]  req_space = 2'd0;
   logic [23:0] req_addr = '0;
   logic        req_we = 1'b0;
   logic [23:0] req_wdata = '0;
   logic [23:0] rd_data;
   logic        addr_err;
   logic        periph_sel;
   logic        periph_we;
   logic [6:0]  periph_addr;
   logic [23:0] periph_wdata;
   logic [23:0] periph_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   // external peripheral model: index-tagged constant
   assign periph_rdata = 24'hA50000 | {17'd0, periph_addr};

   xmem_router uut (
      .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_space(req_space),
      .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
      .rd_data(rd_data), .addr_err(addr_err), .periph_sel(periph_sel),
      .periph_we(periph_we), .periph_addr(periph_addr),
      .periph_wdata(periph_wdata), .periph_rdata(periph_rdata)
   );

   function automatic logic [23:0] pat(input int sp, input int a);
      return 24'((a * 40503 + sp * 7919 + 1) ^ (a << 11));
   endfunction

   task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] sp, input int a, input logic we, input logic [23:0] wd);
      @(negedge clk);
      req_en = 1'b1; req_space = sp; req_addr = 24'(a); req_we = we; req_wdata = wd;
   endtask

   task automatic idle();
      @(negedge clk);
      req_en = 1'b0; req_we = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sp, input int a, input logic [23:0] wd);
      issue(sp, a, 1'b1, wd);
      idle();
   endtask

   task automatic rd(input logic [1:0] sp, input int a, input logic [23:0] exp, input string tag);
      issue(sp, a, 1'b0, '0);
      idle();
      chk(rd_data, exp, tag);
   endtask

   task automatic bad(input logic [1:0] sp, input int a, input logic we, input string tag);
      issue(sp, a, we, 24'h5EED01);
      #1 chk({23'd0, periph_sel}, 24'd0, {tag, " R6 no periph"});
      idle();
      chk({23'd0, addr_err}, 24'd1, {tag, " R6 err pulse"});
      chk(rd_data, 24'd0, {tag, " R6 err data zero"});
      @(negedge clk);
      chk({23'd0, addr_err}, 24'd0, {tag, " R6 pulse one cycle"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8
      chk(rd_data, 24'd0, "R8 rd_data after reset");
      chk({23'd0, addr_err}, 24'd0, "R8 addr_err after reset");
      chk({23'd0, periph_sel}, 24'd0, "R8 periph_sel after reset");

      // fill every mapped word
      for (int a = 0; a < 4096; a++) wr(2'd0, a, pat(0, a));
      chk(rd_data, 24'd0, "R9 rd_data after write");
      for (int a = 0; a < 2048; a++) wr(2'd1, a, pat(1, a));
      for (int a = 0; a < 4096; a++) wr(2'd2, a, pat(2, a));

      // R1
      for (int a = 0; a < 3072; a++) rd(2'd0, a, pat(0, a), "R1 xram read");
      // R2
      for (int a = 3072; a < 4096; a++) rd(2'd0, a, pat(0, a), "R2 mix primary read");
      // R3 read through alias what primary wrote
      for (int i = 0; i < 1024; i++) rd(2'd0, 5120 + i, pat(0, 3072 + i), "R3 alias read");
      // R4
      for (int a = 0; a < 2048; a++) rd(2'd1, a, pat(1, a), "R4 yram read");
      for (int a = 0; a < 4096; a++) rd(2'd2, a, pat(2, a), "R4 pram read");
      // R3 write through alias, read through primary
      for (int i = 0; i < 1024; i++) wr(2'd0, 5120 + i, pat(3, i));
      for (int i = 0; i < 1024; i++) rd(2'd0, 3072 + i, pat(3, i), "R3 primary sees alias write");
      rd(2'd0, 3071, pat(0, 3071), "R1 xram top untouched by mix");

      // R5 peripheral write
      issue(2'd0, 24'hFFFF85, 1'b1, 24'h123456);
      #1;
      chk({23'd0, periph_sel}, 24'd1, "R5 periph_sel on write");
      chk({23'd0, periph_we}, 24'd1, "R5 periph_we on write");
      chk({17'd0, periph_addr}, 24'd5, "R5 periph_addr");
      chk(periph_wdata, 24'h123456, "R5 periph_wdata");
      idle();
      chk({23'd0, addr_err}, 24'd0, "R5 no error on periph");
      rd(2'd0, 5, pat(0, 5), "R5 xram untouched by periph write");
      // R5 peripheral reads at both window ends
      issue(2'd0, 24'hFFFFFF, 1'b0, '0);
      #1;
      chk({23'd0, periph_we}, 24'd0, "R5 periph_we low on read");
      chk({17'd0, periph_addr}, 24'd127, "R5 periph_addr top");
      idle();
      chk(rd_data, 24'hA5007F, "R5 periph read data top");
      rd(2'd0, 24'hFFFF80, 24'hA50000, "R5 periph read data base");
      // Y space at the same address is not peripheral
      bad(2'd1, 24'hFFFF85, 1'b0, "R5 Y high addr");

      // R6 unmapped reads
      bad(2'd0, 4096, 1'b0, "X gap low");
      bad(2'd0, 5119, 1'b0, "X gap high");
      bad(2'd0, 6144, 1'b0, "X above alias");
      bad(2'd0, 24'hFFFF7F, 1'b0, "X below periph");
      bad(2'd1, 2048, 1'b0, "Y past end");
      bad(2'd2, 4096, 1'b0, "P past end");
      bad(2'd3, 0, 1'b0, "space 3");

      // R7 unmapped writes change nothing
      bad(2'd0, 4096, 1'b1, "R7 X gap write");
      bad(2'd0, 6144, 1'b1, "R7 X high write");
      bad(2'd1, 2048, 1'b1, "R7 Y write");
      bad(2'd2, 4096, 1'b1, "R7 P write");
      bad(2'd3, 0, 1'b1, "R7 space 3 write");
      rd(2'd0, 0, pat(0, 0), "R7 xram 0 intact");
      rd(2'd0, 3072, pat(3, 0), "R7 mix 0 intact");
      rd(2'd1, 0, pat(1, 0), "R7 yram 0 intact");
      rd(2'd2, 0, pat(2, 0), "R7 pram 0 intact");

      // R6 + R5 same cycle: error pulse alongside a peripheral strobe
      issue(2'd0, 4500, 1'b0, '0);
      issue(2'd0, 24'hFFFF90, 1'b0, '0);
      #1;
      chk({23'd0, addr_err}, 24'd1, "R6 err with next periph");
      chk({23'd0, periph_sel}, 24'd1, "R5 periph with prior err");
      idle();
      chk({23'd0, addr_err}, 24'd0, "R6 err cleared after periph");
      chk(rd_data, 24'hA50010, "R5 periph data after err");

      // R9 idle
      @(negedge clk);
      chk(rd_data, 24'd0, "R9 rd_data idle");
      chk({23'd0, addr_err}, 24'd0, "R9 addr_err idle");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule